// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break Generation

This block turns bytes written from a CPU-side bus into asynchronous serial frames on a single output line. Each data frame has ten bit times: a low start bit, eight data bits with the least significant bit first, and a high stop bit. The bit period comes from an enable-tick divider that a run-time divisor input sets. A holding register sits in front of the shift register, so software can queue the next byte while the current one is still going out.

Software follows a two-step acknowledge protocol. It reads status, and that read captures which flags were set. It then writes the data register, and the write clears the captured flags. A write made without that prior read still updates the holding byte, but it does not mark the byte as ready to send. A level-sensitive break control sends whole ten-bit all-low frames once the current frame has finished. A pulse input queues one ten-bit all-high idle preamble. When several kinds of frame are waiting, break goes first, then idle, then data.

Top module: `uart_break_tx`

## Requirements
- R1: After reset the serial line is high, and both the holding-empty flag and the transmit-complete flag read 1.
- R2: One bit period lasts baudDiv+1 clock cycles. The first divider tick comes on the first clock after reset, and the serial line changes only on the clock that follows a tick.
- R3: A data frame is driven as one low start bit, then the eight data bits with the least significant bit first, then one high stop bit. Each bit lasts one bit period.
- R4: The acknowledge sequence is a cycle with statusRd high, followed later by a cycle with wrEn high. If the status read saw holdEmpty=1, the write clears holdEmpty. On the next tick at which no frame is running, or at which the last bit of the current frame ends, the byte moves to the shifter. On that same clock holdEmpty returns to 1 and the start bit appears.
- R5: A write while holdEmpty=0 replaces the waiting byte, and the earlier byte is never sent.
- R6: A write made without an acknowledging status read while holdEmpty=1 leaves holdEmpty at 1, and nothing is sent. The line stays high.
- R7: If sendBreak is raised during a frame, that frame completes. Ten-bit all-low frames then follow back to back, for as long as sendBreak stays high.
- R8: A sendBreak pulse shorter than one frame produces one or two break frames. The line then returns to idle or to pending data.
- R9: A one-cycle idleReq queues one ten-bit all-high frame. At a frame boundary the choice is break first, then idle preamble, then pending data.
- R10: txDone rises on the tick that ends the last frame when nothing else is queued, whether that frame was data, idle or break. It falls when any frame starts from idle, or on a write that follows a status read which saw txDone=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| baudDiv | input | 16 | Bit period minus one, in clocks |
| wrData | input | 8 | Byte for the holding register |
| wrEn | input | 1 | Data register write strobe |
| statusRd | input | 1 | Status read strobe; captures the flags for acknowledge |
| sendBreak | input | 1 | Level control requesting break frames |
| idleReq | input | 1 | Pulse queuing one idle preamble frame |
| txLine | output | 1 | Serial output, idles high |
| holdEmpty | output | 1 | Holding register may take a new byte |
| txDone | output | 1 | Transmitter has finished all queued frames |

## Verification
The assertions assume that statusRd and wrEn are never high in the same cycle, and that reset is held for at least one clock edge. The stimulus keeps to this: every bus access in the bench is a one-cycle strobe from a task that issues one access at a time. baudDiv is changed only while the line is quiet, so no frame is ever stretched across two bit rates. sendBreak and idleReq pulses are placed at several offsets inside a running frame, so the one-break and two-break outcomes both occur.

// File: rtl/tx_pkg.sv
package tx_pkg;
  typedef struct packed {
    logic loadData;
    logic loadBreak;
    logic loadIdle;
    logic shiftOn;
    logic writeHold;
    logic lineActive;
  } txStrobes_t;
endpackage

// File: rtl/tx_baud_gen.sv
module tx_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] baudDiv,
  output logic             tick
);
  logic [DIV_W-1:0] count;

  assign tick = (count == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (tick) begin
      count <= baudDiv;
    end else begin
      count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/tx_ctrl.sv
module tx_ctrl
  import tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       wrEn,
  input  logic       statusRd,
  input  logic       sendBreak,
  input  logic       idleReq,
  output logic       holdEmpty,
  output logic       txDone,
  output txStrobes_t strobes
);
  localparam int FRAME_LEN = DATA_W + 2;
  localparam int CNT_W = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_LEN - 1);

  logic             busy;
  logic [CNT_W-1:0] bitCnt;
  logic             breakPend;
  logic             idlePend;
  logic             armEmpty;
  logic             armDone;

  logic frameEnd, decide, brkWant;
  logic startBrk, startIdl, startDat, anyStart, goQuiet;

  always_comb begin
    frameEnd = busy && (bitCnt == LAST_BIT);
    decide   = tick && (!busy || frameEnd);
    brkWant  = breakPend | sendBreak;
    startBrk = decide & brkWant;
    startIdl = decide & ~brkWant & idlePend;
    startDat = decide & ~brkWant & ~idlePend & ~holdEmpty;
    anyStart = startBrk | startIdl | startDat;
    goQuiet  = decide & busy & ~anyStart;
  end

  always_comb begin
    strobes.loadData   = startDat;
    strobes.loadBreak  = startBrk;
    strobes.loadIdle   = startIdl;
    strobes.shiftOn    = tick & busy & ~frameEnd;
    strobes.writeHold  = wrEn;
    strobes.lineActive = busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      bitCnt    <= '0;
      breakPend <= 1'b0;
      idlePend  <= 1'b0;
      holdEmpty <= 1'b1;
      txDone    <= 1'b1;
      armEmpty  <= 1'b0;
      armDone   <= 1'b0;
    end else begin
      if (anyStart) begin
        busy   <= 1'b1;
        bitCnt <= '0;
      end else if (goQuiet) begin
        busy <= 1'b0;
      end else if (tick && busy) begin
        bitCnt <= bitCnt + 1'b1;
      end

      breakPend <= startBrk ? sendBreak : brkWant;
      idlePend  <= (idlePend & ~startIdl) | idleReq;

      if (startDat) begin
        holdEmpty <= 1'b1;
      end else if (wrEn && armEmpty) begin
        holdEmpty <= 1'b0;
      end

      if (goQuiet) begin
        txDone <= 1'b1;
      end else if (anyStart) begin
        txDone <= 1'b0;
      end else if (wrEn && armDone) begin
        txDone <= 1'b0;
      end

      if (wrEn) begin
        armEmpty <= 1'b0;
        armDone  <= 1'b0;
      end else if (statusRd) begin
        armEmpty <= holdEmpty;
        armDone  <= txDone;
      end
    end
  end
endmodule

// File: rtl/tx_datapath.sv
module tx_datapath
  import tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic              txLine
);
  localparam int FRAME_LEN = DATA_W + 2;

  logic [DATA_W-1:0]    holdReg;
  logic [FRAME_LEN-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg  <= '0;
      shiftReg <= '1;
    end else begin
      if (strobes.writeHold) begin
        holdReg <= wrData;
      end
      if (strobes.loadData) begin
        shiftReg <= {1'b1, holdReg, 1'b0};
      end else if (strobes.loadBreak) begin
        shiftReg <= '0;
      end else if (strobes.loadIdle) begin
        shiftReg <= '1;
      end else if (strobes.shiftOn) begin
        shiftReg <= {1'b1, shiftReg[FRAME_LEN-1:1]};
      end
    end
  end

  assign txLine = strobes.lineActive ? shiftReg[0] : 1'b1;
endmodule

// File: rtl/uart_break_tx.sv
module uart_break_tx
  import tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  baudDiv,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              statusRd,
  input  logic              sendBreak,
  input  logic              idleReq,
  output logic              txLine,
  output logic              holdEmpty,
  output logic              txDone
);
  logic       bitTick;
  txStrobes_t strobes;

  tx_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rstN(rstN), .baudDiv(baudDiv), .tick(bitTick)
  );

  tx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(bitTick), .wrEn(wrEn),
    .statusRd(statusRd), .sendBreak(sendBreak), .idleReq(idleReq),
    .holdEmpty(holdEmpty), .txDone(txDone), .strobes(strobes)
  );

  tx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .txLine(txLine)
  );
endmodule

// File: rtl/tx_checker.sv
module tx_checker (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic tick,
  input logic txLine,
  input logic holdEmpty,
  input logic txDone
);
  assert_quiet_line_high_R10: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> txLine);

  assert_line_moves_on_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txLine) |-> $past(tick));

  assert_load_drives_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdEmpty) |-> !txLine);

  assert_empty_clears_on_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdEmpty) |-> $past(wrEn));

  assert_done_falls_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txDone) |-> ($past(wrEn) || $past(tick)));
endmodule

bind uart_break_tx tx_checker u_tx_checker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .tick(bitTick),
  .txLine(txLine), .holdEmpty(holdEmpty), .txDone(txDone)
);

// File: tb/test_uart_break_tx.sv
`timescale 1ns/1ps
module test_uart_break_tx;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] baudDiv = 16'd3;
  logic [7:0]  wrData = 8'h00;
  logic        wrEn = 1'b0;
  logic        statusRd = 1'b0;
  logic        sendBreak = 1'b0;
  logic        idleReq = 1'b0;
  logic        txLine, holdEmpty, txDone;

  int    checks = 0;
  int    fails = 0;
  string curReq = "R1";

  always #10 clk = ~clk;

  uart_break_tx i_uart_break_tx (
    .clk(clk), .rstN(rstN), .baudDiv(baudDiv), .wrData(wrData),
    .wrEn(wrEn), .statusRd(statusRd), .sendBreak(sendBreak),
    .idleReq(idleReq), .txLine(txLine), .holdEmpty(holdEmpty),
    .txDone(txDone)
  );

  // behavioural reference model
  int       divCnt;
  bit       bitQ[$];
  bit       mEmpty, mDone, mArmE, mArmT, mBrk, mIdle;
  bit [7:0] mHold;

  always @(posedge clk) begin
    if (!rstN) begin
      divCnt = 0; bitQ.delete();
      mEmpty = 1; mDone = 1; mArmE = 0; mArmT = 0; mBrk = 0; mIdle = 0;
      mHold = 0;
    end else begin
      bit tickNow, wasBusy, brkIn, sBrk, sIdl, sDat, ended;
      bit oEmpty, oDone;
      oEmpty = mEmpty; oDone = mDone;
      tickNow = (divCnt == 0);
      divCnt = tickNow ? int'(baudDiv) : divCnt - 1;
      brkIn = mBrk | sendBreak;
      wasBusy = (bitQ.size() > 0);
      sBrk = 0; sIdl = 0; sDat = 0; ended = 0;
      if (tickNow) begin
        if (wasBusy) void'(bitQ.pop_front());
        if (bitQ.size() == 0) begin
          if (brkIn) begin
            sBrk = 1;
            for (int i = 0; i < 10; i++) bitQ.push_back(1'b0);
          end else if (mIdle) begin
            sIdl = 1;
            for (int i = 0; i < 10; i++) bitQ.push_back(1'b1);
          end else if (!oEmpty) begin
            sDat = 1;
            bitQ.push_back(1'b0);
            for (int i = 0; i < 8; i++) bitQ.push_back(mHold[i]);
            bitQ.push_back(1'b1);
          end else if (wasBusy) begin
            ended = 1;
          end
        end
      end
      mBrk = sBrk ? sendBreak : brkIn;
      mIdle = (mIdle & ~sIdl) | idleReq;
      if (sDat) mEmpty = 1;
      else if (wrEn && mArmE) mEmpty = 0;
      if (ended) mDone = 1;
      else if (sBrk || sIdl || sDat) mDone = 0;
      else if (wrEn && mArmT) mDone = 0;
      if (wrEn) mHold = wrData;
      if (wrEn) begin mArmE = 0; mArmT = 0; end
      else if (statusRd) begin mArmE = oEmpty; mArmT = oDone; end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      bit mLine;
      mLine = (bitQ.size() > 0) ? bitQ[0] : 1'b1;
      check(curReq, "txLine", int'(txLine), int'(mLine));
      check(curReq, "holdEmpty", int'(holdEmpty), int'(mEmpty));
      check(curReq, "txDone", int'(txDone), int'(mDone));
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic statusRead();
    @(negedge clk); statusRd = 1'b1;
    @(negedge clk); statusRd = 1'b0;
  endtask

  task automatic busWrite(input logic [7:0] b);
    @(negedge clk); wrEn = 1'b1; wrData = b;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic ackWrite(input logic [7:0] b);
    statusRead();
    busWrite(b);
  endtask

  task automatic pulseBreak(input int len);
    @(negedge clk); sendBreak = 1'b1;
    waitClk(len);
    sendBreak = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    waitClk(3);
    // R1: reset values seen while reset is held
    check("R1", "txLine in reset", int'(txLine), 1);
    check("R1", "holdEmpty in reset", int'(holdEmpty), 1);
    check("R1", "txDone in reset", int'(txDone), 1);
    rstN = 1'b1;
    waitClk(5);

    curReq = "R3"; ackWrite(8'hA5); waitClk(50);
    curReq = "R4"; ackWrite(8'h01); waitClk(8); ackWrite(8'h80); waitClk(90);
    curReq = "R5";
    ackWrite(8'h11); waitClk(6); ackWrite(8'h22); busWrite(8'h33); waitClk(100);
    curReq = "R6"; busWrite(8'hF0); waitClk(60);
    curReq = "R10"; statusRead(); busWrite(8'h5A); waitClk(60);
    statusRead(); waitClk(2); busWrite(8'h00); waitClk(60);

    curReq = "R7";
    ackWrite(8'hC3); waitClk(10);
    @(negedge clk); sendBreak = 1'b1; waitClk(130); sendBreak = 1'b0;
    waitClk(90);

    curReq = "R8";
    for (int off = 0; off < 12; off++) begin
      ackWrite(8'h69 + 8'(off));
      waitClk(20 + 3 * off);
      pulseBreak(2 + (off % 5) * 6);
      waitClk(130);
    end
    ackWrite(8'h96); waitClk(4); pulseBreak(3); ackWrite(8'h42); waitClk(140);

    curReq = "R9";
    @(negedge clk); idleReq = 1'b1; @(negedge clk); idleReq = 1'b0; waitClk(60);
    ackWrite(8'h3C); waitClk(4);
    @(negedge clk); idleReq = 1'b1; sendBreak = 1'b1;
    @(negedge clk); idleReq = 1'b0; statusRead(); busWrite(8'hE7);
    waitClk(20); sendBreak = 1'b0; waitClk(160);

    curReq = "R2";
    for (int d = 0; d < 3; d++) begin
      baudDiv = (d == 0) ? 16'd0 : (d == 1) ? 16'd6 : 16'd1;
      waitClk(12);
      ackWrite(8'hB4 ^ 8'(d)); waitClk(2);
      statusRead(); busWrite(8'h0F);
      pulseBreak(4);
      waitClk(300);
    end
    summary();
  end
endmodule